// File: doc/BRIEF.md
# SPI Slave with Default and Over-Read Fill Bytes

This block is an SPI slave that runs on the system clock. It oversamples the serial clock, chip select and data-in pins through synchronizers. While chip select is low, it shifts bytes out of a transmit buffer and collects incoming bytes into a receive buffer. A two-bit configuration field selects the clock mode: idle polarity and sampling phase, covering all four combinations. The mode is captured when chip select falls.

Two programmable fill bytes cover the cases where no real data is available:
- A default byte is sent for the whole transaction when software has not handed the buffers to the slave before chip select falls.
- An over-read byte is sent for every byte the master clocks beyond the loaded transmit length.

After chip select falls, the master must wait a setup gap, counted in system-clock cycles, before it clocks. Serial clock edges inside the gap are dropped. When chip select rises, the slave latches the number of bytes sent from the buffer and the number of bytes received. It pulses a done flag and takes the buffers back from the slave.

A small word-addressed register port loads the buffers, the lengths and the fill bytes, and reads back the results. Address bits [5:4] pick a region: 0 for control, 1 for the transmit buffer, 2 for the receive buffer. Bits [3:0] give the slot.

Top module: `spi_fill_slave`

## Requirements
- R1: After reset the default byte (control slot 3) reads 0xAA, the over-read byte (slot 4) reads 0x55, the mode (slot 0) reads 0, the ready flag (slot 5) reads 0, both result counts (slots 6 and 7) read 0, and the MISO enable is low.
- R2: Control slot 0 bits [1:0] select the clock mode, with bit 1 as idle clock polarity and bit 0 as phase. Mode 0 samples on the rising edge from idle low. Mode 1 samples on the falling edge from idle low. Mode 2 samples on the falling edge from idle high. Mode 3 samples on the rising edge from idle high. The value is captured when chip select falls.
- R3: Bytes move MSB first. Transmit byte i is read from address 0x10+i. Received byte i is stored at address 0x20+i.
- R4: In modes 0 and 2, bit 7 of the first outgoing byte is on MISO once chip select is low and the setup gap has passed, before any clock edge.
- R5: When the slave owns the buffers, every byte at index min(TXLEN, DEPTH) or above is sent as the over-read byte (slot 4). TXLEN is control slot 1.
- R6: When the ready flag (slot 5 bit 0) is clear as chip select falls, every byte sent is the default byte (slot 3). The receive buffer is left unchanged, and the transmit count reports 0.
- R7: Serial clock edges during the SETUP_CYC cycles after chip select falls are ignored.
- R8: Received bytes at index min(RXLEN, DEPTH) or above are dropped. RXLEN is control slot 2. The receive count (slot 7) still counts every complete byte.
- R9: When chip select rises, xfer_done pulses for exactly one cycle. Slot 6 then holds the number of complete bytes that came from the transmit buffer, slot 7 holds the number of complete bytes received, and an owned ready flag reads 0.
- R10: MISO enable is high during a transaction and low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Drive enable for MISO; low means released |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register and buffer address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| xfer_done | output | 1 | One-cycle pulse when a transaction ends |

## Verification
Each pin passes through two synchronizer stages and one edge register. An action taken on a pin edge therefore shows at the outputs about three system clocks after the edge: MISO after a shift edge, the enable after a chip-select change, and xfer_done plus the counts after chip select rises. The bench keeps every SCK half period at eight system clocks and samples MISO one full half period after the slave's shift edge, so every bit has settled when it is read. Register reads and post-transaction checks are taken on the falling clock edge, twelve cycles after chip select rises, well after the three-cycle window.

// File: rtl/spi_fill_pkg.sv
package spi_fill_pkg;

  localparam int LEN_W = 8;
  typedef logic [7:0]       byte_t;
  typedef logic [LEN_W-1:0] len_t;

  // control slots (low address bits inside the control region)
  localparam logic [2:0] SLOT_MODE  = 3'd0;
  localparam logic [2:0] SLOT_TXLEN = 3'd1;
  localparam logic [2:0] SLOT_RXLEN = 3'd2;
  localparam logic [2:0] SLOT_DEF   = 3'd3;
  localparam logic [2:0] SLOT_OVR   = 3'd4;
  localparam logic [2:0] SLOT_READY = 3'd5;
  localparam logic [2:0] SLOT_TXCNT = 3'd6;
  localparam logic [2:0] SLOT_RXCNT = 3'd7;

  // address regions (top two address bits)
  localparam logic [1:0] REGION_CTRL  = 2'd0;
  localparam logic [1:0] REGION_TXBUF = 2'd1;
  localparam logic [1:0] REGION_RXBUF = 2'd2;

  localparam byte_t DEF_RESET = 8'hAA;
  localparam byte_t OVR_RESET = 8'h55;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  // edge that opens a bit cell for the given polarity
  function automatic logic lead_edge(spi_mode_t m, logic rise, logic fall);
    return m.cpol ? fall : rise;
  endfunction

  function automatic logic trail_edge(spi_mode_t m, logic rise, logic fall);
    return m.cpol ? rise : fall;
  endfunction

  function automatic len_t clamp_len(len_t len, len_t limit);
    return (len > limit) ? limit : len;
  endfunction

  function automatic len_t sat_inc(len_t v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  // selects the byte placed on MISO for outgoing slot idx
  function automatic byte_t pick_byte(logic owned, len_t idx, len_t len,
                                      byte_t buf_b, byte_t def_b, byte_t ovr_b);
    if (!owned)
      return def_b;
    else if (idx < len)
      return buf_b;
    else
      return ovr_b;
  endfunction

endpackage

// File: rtl/spi_fill_sync.sv
module spi_fill_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[0] <= RESET_VAL;
          else        stage[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= RESET_VAL;
          else        stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/spi_fill_regs.sv
module spi_fill_regs
  import spi_fill_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  byte_t             reg_wdata,
  output byte_t             reg_rdata,
  output spi_mode_t         cfg_mode,
  output len_t              txlen_eff,
  output len_t              rxlen_eff,
  output byte_t             def_b,
  output byte_t             ovr_b,
  output logic              ready,
  input  len_t              tx_idx,
  output byte_t             tx_data,
  input  logic              rx_we,
  input  len_t              rx_widx,
  input  byte_t             rx_wdata,
  input  logic              release_own,
  input  len_t              last_tx,
  input  len_t              last_rx
);

  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SLOT_W = ADDR_W - 2;

  logic [1:0]        region;
  logic [SLOT_W-1:0] slot;
  logic              slot_ok;

  spi_mode_t mode_r;
  len_t      txlen_r, rxlen_r;
  byte_t     def_r, ovr_r;
  logic      ready_r;
  byte_t     tx_mem [DEPTH];
  byte_t     rx_mem [DEPTH];

  assign region  = reg_addr[ADDR_W-1 -: 2];
  assign slot    = reg_addr[SLOT_W-1:0];
  assign slot_ok = 32'(slot) < 32'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r  <= '0;
      txlen_r <= '0;
      rxlen_r <= '0;
      def_r   <= DEF_RESET;
      ovr_r   <= OVR_RESET;
      ready_r <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        tx_mem[i] <= '0;
        rx_mem[i] <= '0;
      end
    end else begin
      if (reg_we) begin
        if (region == REGION_CTRL) begin
          case (slot[2:0])
            SLOT_MODE:  mode_r  <= spi_mode_t'(reg_wdata[1:0]);
            SLOT_TXLEN: txlen_r <= reg_wdata;
            SLOT_RXLEN: rxlen_r <= reg_wdata;
            SLOT_DEF:   def_r   <= reg_wdata;
            SLOT_OVR:   ovr_r   <= reg_wdata;
            SLOT_READY: ready_r <= reg_wdata[0];
            default: ;
          endcase
        end else if (region == REGION_TXBUF && slot_ok) begin
          tx_mem[slot[IDX_W-1:0]] <= reg_wdata;
        end
      end
      if (release_own)
        ready_r <= 1'b0;
      if (rx_we && 32'(rx_widx) < 32'(DEPTH))
        rx_mem[rx_widx[IDX_W-1:0]] <= rx_wdata;
    end
  end

  assign cfg_mode  = mode_r;
  assign txlen_eff = clamp_len(txlen_r, len_t'(DEPTH));
  assign rxlen_eff = clamp_len(rxlen_r, len_t'(DEPTH));
  assign def_b     = def_r;
  assign ovr_b     = ovr_r;
  assign ready     = ready_r;
  assign tx_data   = (32'(tx_idx) < 32'(DEPTH)) ? tx_mem[tx_idx[IDX_W-1:0]] : '0;

  always_comb begin
    reg_rdata = '0;
    case (region)
      REGION_CTRL: begin
        case (slot[2:0])
          SLOT_MODE:  reg_rdata = {6'd0, mode_r};
          SLOT_TXLEN: reg_rdata = txlen_r;
          SLOT_RXLEN: reg_rdata = rxlen_r;
          SLOT_DEF:   reg_rdata = def_r;
          SLOT_OVR:   reg_rdata = ovr_r;
          SLOT_READY: reg_rdata = {7'd0, ready_r};
          SLOT_TXCNT: reg_rdata = last_tx;
          SLOT_RXCNT: reg_rdata = last_rx;
          default:    reg_rdata = '0;
        endcase
      end
      REGION_TXBUF: if (slot_ok) reg_rdata = tx_mem[slot[IDX_W-1:0]];
      REGION_RXBUF: if (slot_ok) reg_rdata = rx_mem[slot[IDX_W-1:0]];
      default:      reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_fill_engine.sv
module spi_fill_engine
  import spi_fill_pkg::*;
#(
  parameter int SETUP_CYC = 1775
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n_s,
  input  logic      sck_s,
  input  logic      mosi_s,
  input  spi_mode_t cfg_mode,
  input  len_t      txlen_eff,
  input  len_t      rxlen_eff,
  input  byte_t     def_b,
  input  byte_t     ovr_b,
  input  logic      ready,
  output len_t      tx_idx,
  input  byte_t     tx_data,
  output logic      rx_we,
  output len_t      rx_widx,
  output byte_t     rx_wdata,
  output logic      release_own,
  output logic      miso,
  output logic      miso_oe,
  output logic      xfer_done,
  output len_t      last_tx,
  output len_t      last_rx,
  output logic      start_ev,
  output logic      end_ev,
  output logic      samp_ev,
  output logic      shift_ev,
  output logic      active,
  output spi_mode_t mode_q
);

  localparam int GAP_W = (SETUP_CYC > 0) ? $clog2(SETUP_CYC + 1) : 1;

  logic             cs_q, sck_q;
  logic [GAP_W-1:0] gap_cnt;
  logic             owned;
  byte_t            tx_sh;
  logic [6:0]       rx_sh;
  logic [2:0]       bit_cnt, sh_cnt;
  len_t             next_idx, byte_cnt, tx_cnt;
  logic             sck_rise, sck_fall, edges_ok, byte_done, load_slot;
  byte_t            next_byte;

  assign sck_rise = ~sck_q & sck_s;
  assign sck_fall = sck_q & ~sck_s;
  assign start_ev = cs_q & ~cs_n_s;
  assign end_ev   = active & ~cs_q & cs_n_s;
  assign edges_ok = active & ~cs_n_s & (gap_cnt == '0);

  // CPHA=0 samples on the leading edge, CPHA=1 on the trailing edge
  assign samp_ev  = edges_ok & (mode_q.cpha ? trail_edge(mode_q, sck_rise, sck_fall)
                                            : lead_edge(mode_q, sck_rise, sck_fall));
  assign shift_ev = edges_ok & (mode_q.cpha ? lead_edge(mode_q, sck_rise, sck_fall)
                                            : trail_edge(mode_q, sck_rise, sck_fall));

  assign byte_done = samp_ev & (bit_cnt == 3'd7);
  // CPHA=1 loads on the first shift edge of a byte, CPHA=0 on the eighth
  assign load_slot = mode_q.cpha ? (sh_cnt == 3'd0) : (sh_cnt == 3'd7);

  assign tx_idx    = start_ev ? '0 : next_idx;
  assign next_byte = pick_byte(start_ev ? ready : owned, tx_idx, txlen_eff,
                               tx_data, def_b, ovr_b);

  assign rx_we       = byte_done & owned & (byte_cnt < rxlen_eff);
  assign rx_widx     = byte_cnt;
  assign rx_wdata    = {rx_sh, mosi_s};
  assign release_own = end_ev & owned;

  assign miso    = active & tx_sh[7];
  assign miso_oe = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
      gap_cnt   <= '0;
      active    <= 1'b0;
      owned     <= 1'b0;
      mode_q    <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      bit_cnt   <= '0;
      sh_cnt    <= '0;
      next_idx  <= '0;
      byte_cnt  <= '0;
      tx_cnt    <= '0;
      last_tx   <= '0;
      last_rx   <= '0;
      xfer_done <= 1'b0;
    end else begin
      cs_q      <= cs_n_s;
      sck_q     <= sck_s;
      xfer_done <= end_ev;
      if (gap_cnt != '0)
        gap_cnt <= gap_cnt - 1'b1;

      if (start_ev) begin
        active   <= 1'b1;
        owned    <= ready;
        mode_q   <= cfg_mode;
        gap_cnt  <= GAP_W'(SETUP_CYC);
        tx_sh    <= next_byte;
        next_idx <= cfg_mode.cpha ? len_t'(0) : len_t'(1);
        sh_cnt   <= '0;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        tx_cnt   <= '0;
        rx_sh    <= '0;
      end else if (end_ev) begin
        active  <= 1'b0;
        owned   <= 1'b0;
        last_tx <= tx_cnt;
        last_rx <= byte_cnt;
      end else begin
        if (shift_ev) begin
          if (load_slot) begin
            tx_sh    <= next_byte;
            next_idx <= sat_inc(next_idx);
          end else begin
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
          sh_cnt <= sh_cnt + 3'd1;
        end
        if (samp_ev) begin
          rx_sh   <= {rx_sh[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (byte_done) begin
            byte_cnt <= sat_inc(byte_cnt);
            if (owned && byte_cnt < txlen_eff)
              tx_cnt <= sat_inc(tx_cnt);
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_fill_slave.sv
module spi_fill_slave
  import spi_fill_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int ADDR_W      = 6,
  parameter int SETUP_CYC   = 1775,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              xfer_done
);

  logic [2:0] pins_s;
  logic       cs_n_s, sck_s, mosi_s;

  spi_mode_t cfg_mode, eng_mode;
  len_t      txlen_eff, rxlen_eff, tx_idx, rx_widx, last_tx, last_rx;
  byte_t     def_b, ovr_b, tx_data, rx_wdata;
  logic      ready, rx_we, release_own;
  logic      eng_start, eng_end, eng_samp, eng_shift, eng_active;

  spi_fill_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_cs_n, spi_sck, spi_mosi}),
    .q    (pins_s)
  );

  assign cs_n_s = pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_fill_regs #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cfg_mode   (cfg_mode),
    .txlen_eff  (txlen_eff),
    .rxlen_eff  (rxlen_eff),
    .def_b      (def_b),
    .ovr_b      (ovr_b),
    .ready      (ready),
    .tx_idx     (tx_idx),
    .tx_data    (tx_data),
    .rx_we      (rx_we),
    .rx_widx    (rx_widx),
    .rx_wdata   (rx_wdata),
    .release_own(release_own),
    .last_tx    (last_tx),
    .last_rx    (last_rx)
  );

  spi_fill_engine #(
    .SETUP_CYC(SETUP_CYC)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_s     (cs_n_s),
    .sck_s      (sck_s),
    .mosi_s     (mosi_s),
    .cfg_mode   (cfg_mode),
    .txlen_eff  (txlen_eff),
    .rxlen_eff  (rxlen_eff),
    .def_b      (def_b),
    .ovr_b      (ovr_b),
    .ready      (ready),
    .tx_idx     (tx_idx),
    .tx_data    (tx_data),
    .rx_we      (rx_we),
    .rx_widx    (rx_widx),
    .rx_wdata   (rx_wdata),
    .release_own(release_own),
    .miso       (spi_miso),
    .miso_oe    (spi_miso_oe),
    .xfer_done  (xfer_done),
    .last_tx    (last_tx),
    .last_rx    (last_rx),
    .start_ev   (eng_start),
    .end_ev     (eng_end),
    .samp_ev    (eng_samp),
    .shift_ev   (eng_shift),
    .active     (eng_active),
    .mode_q     (eng_mode)
  );

endmodule

// File: rtl/spi_fill_slave_chk.sv
module spi_fill_slave_chk
  import spi_fill_pkg::*;
#(
  parameter int SETUP_CYC   = 1775,
  parameter int SYNC_STAGES = 2
) (
  input logic      clk,
  input logic      rst_n,
  input logic      spi_cs_n,
  input logic      spi_miso_oe,
  input logic      xfer_done,
  input logic      start_ev,
  input logic      samp_ev,
  input logic      shift_ev,
  input logic      active,
  input spi_mode_t mode_q,
  input logic      rx_we,
  input len_t      rx_widx,
  input len_t      rxlen_eff,
  input len_t      txlen_eff,
  input len_t      last_tx
);

  localparam int GAP_W = (SETUP_CYC > 0) ? $clog2(SETUP_CYC + 1) : 1;

  logic [GAP_W-1:0]       since_start;
  logic [SYNC_STAGES+1:0] cs_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_start <= '0;
      cs_hist     <= '1;
    end else begin
      cs_hist <= {cs_hist[SYNC_STAGES:0], spi_cs_n};
      if (start_ev)
        since_start <= '0;
      else if (since_start != GAP_W'(SETUP_CYC))
        since_start <= since_start + 1'b1;
    end
  end

  // R10
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && (&cs_hist)) |-> !spi_miso_oe);

  // R7
  gap_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_ev || shift_ev) |-> (since_start == GAP_W'(SETUP_CYC)));

  // R8
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (rx_widx < rxlen_eff));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R9
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> cs_hist[SYNC_STAGES]);

  // R5
  txcount_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (last_tx <= txlen_eff));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(mode_q));

endmodule

bind spi_fill_slave spi_fill_slave_chk #(
  .SETUP_CYC  (SETUP_CYC),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_cs_n   (spi_cs_n),
  .spi_miso_oe(spi_miso_oe),
  .xfer_done  (xfer_done),
  .start_ev   (eng_start),
  .samp_ev    (eng_samp),
  .shift_ev   (eng_shift),
  .active     (eng_active),
  .mode_q     (eng_mode),
  .rx_we      (rx_we),
  .rx_widx    (rx_widx),
  .rxlen_eff  (rxlen_eff),
  .txlen_eff  (txlen_eff),
  .last_tx    (last_tx)
);

// File: tb/spi_fill_slave_test.sv
module spi_fill_slave_test;

  localparam int GAP = 1775;
  localparam int HP  = 8;

  localparam logic [5:0] A_MODE  = 6'h00;
  localparam logic [5:0] A_TXLEN = 6'h01;
  localparam logic [5:0] A_RXLEN = 6'h02;
  localparam logic [5:0] A_DEF   = 6'h03;
  localparam logic [5:0] A_OVR   = 6'h04;
  localparam logic [5:0] A_READY = 6'h05;
  localparam logic [5:0] A_TXCNT = 6'h06;
  localparam logic [5:0] A_RXCNT = 6'h07;
  localparam logic [5:0] A_TXB   = 6'h10;
  localparam logic [5:0] A_RXB   = 6'h20;

  logic       clk = 1'b0;
  logic       rst_n, sck, cs_n, mosi, we;
  logic [5:0] addr;
  logic [7:0] wdata;
  wire  [7:0] rdata;
  wire        miso, oe, done;

  always #2 clk = ~clk;

  spi_fill_slave #(.SETUP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .xfer_done(done)
  );

  int checks = 0, fails = 0, done_seen = 0;
  logic [7:0] m_out [8];
  logic [7:0] m_got [8];

  always @(posedge clk) if (done) done_seen++;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; we = 1'b0; #1; v = rdata;
  endtask

  task automatic rd_check(input string tag, input logic [5:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic spi_xfer(input int mode, input int n, input bit early, input logic [7:0] first_exp);
    logic cpol, cpha;
    cpol = mode[1]; cpha = mode[0];
    @(negedge clk); sck = cpol; mosi = 1'b0;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    if (early) begin
      repeat (40) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        mosi = 1'b1; sck = ~cpol; repeat (HP) @(negedge clk);
        sck = cpol; repeat (HP) @(negedge clk);
      end
      mosi = 1'b0;
    end
    repeat (GAP + 20) @(negedge clk);
    check("R10 enable high during transaction", oe, 1);
    if (!cpha) check("R4 first bit before clocking", miso, first_exp[7]);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (!cpha) begin
          mosi = m_out[b][i]; repeat (HP) @(negedge clk);
          m_got[b][i] = miso; sck = ~cpol; repeat (HP) @(negedge clk);
          sck = cpol;
        end else begin
          mosi = m_out[b][i]; sck = ~cpol; repeat (HP) @(negedge clk);
          m_got[b][i] = miso; sck = cpol; repeat (HP) @(negedge clk);
        end
      end
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1 enable low after reset", oe, 0);
    check("R10 enable low while idle", oe, 0);
    rd_check("R1 default byte reset", A_DEF, 8'hAA);
    rd_check("R1 over-read byte reset", A_OVR, 8'h55);
    rd_check("R1 mode reset", A_MODE, 0);
    rd_check("R1 ready reset", A_READY, 0);
    rd_check("R1 tx count reset", A_TXCNT, 0);
    rd_check("R1 rx count reset", A_RXCNT, 0);
  endtask

  task automatic test_mode0_owned();
    int d0;
    wr(A_MODE, 0);
    wr(A_TXB + 0, 8'h3C); wr(A_TXB + 1, 8'hA5); wr(A_TXB + 2, 8'h0F);
    wr(A_TXLEN, 3); wr(A_RXLEN, 4); wr(A_READY, 1);
    for (int i = 0; i < 5; i++) m_out[i] = 8'h11 * (i + 1);
    d0 = done_seen;
    spi_xfer(0, 5, 1'b0, 8'h3C);
    check("R3 byte0 from buffer", m_got[0], 8'h3C);
    check("R3 byte1 from buffer", m_got[1], 8'hA5);
    check("R3 byte2 from buffer", m_got[2], 8'h0F);
    check("R5 over-read byte3", m_got[3], 8'h55);
    check("R5 over-read byte4", m_got[4], 8'h55);
    rd_check("R3 rx slot0", A_RXB + 0, 8'h11);
    rd_check("R3 rx slot3", A_RXB + 3, 8'h44);
    rd_check("R8 rx slot4 untouched", A_RXB + 4, 8'h00);
    rd_check("R9 tx count", A_TXCNT, 3);
    rd_check("R8 rx count includes dropped", A_RXCNT, 5);
    rd_check("R9 ready released", A_READY, 0);
    check("R9 one done pulse", done_seen - d0, 1);
    check("R10 enable low after end", oe, 0);
  endtask

  task automatic test_other_modes();
    logic [7:0] b0, b1;
    wr(A_OVR, 8'h77);
    for (int m = 1; m < 4; m++) begin
      b0 = 8'h81 ^ 8'(m); b1 = 8'hC6 + 8'(m);
      wr(A_MODE, 8'(m));
      wr(A_TXB + 0, b0); wr(A_TXB + 1, b1);
      wr(A_TXLEN, 2); wr(A_RXLEN, 3); wr(A_READY, 1);
      m_out[0] = 8'h5A; m_out[1] = 8'hF0; m_out[2] = 8'(m);
      spi_xfer(m, 3, 1'b0, b0);
      check($sformatf("R2 mode %0d byte0", m), m_got[0], b0);
      check($sformatf("R2 mode %0d byte1", m), m_got[1], b1);
      check($sformatf("R5 mode %0d over-read", m), m_got[2], 8'h77);
      rd_check($sformatf("R2 mode %0d rx slot1", m), A_RXB + 1, 8'hF0);
      rd_check($sformatf("R2 mode %0d rx slot2", m), A_RXB + 2, m);
      rd_check($sformatf("R9 mode %0d tx count", m), A_TXCNT, 2);
    end
  endtask

  task automatic test_not_ready();
    wr(A_MODE, 0); wr(A_DEF, 8'hC3); wr(A_READY, 0);
    m_out[0] = 8'h99; m_out[1] = 8'h66;
    spi_xfer(0, 2, 1'b0, 8'hC3);
    check("R6 default byte0", m_got[0], 8'hC3);
    check("R6 default byte1", m_got[1], 8'hC3);
    rd_check("R6 rx slot0 unchanged", A_RXB + 0, 8'h5A);
    rd_check("R6 tx count zero", A_TXCNT, 0);
    rd_check("R8 rx count", A_RXCNT, 2);
  endtask

  task automatic test_early_edges();
    wr(A_MODE, 0);
    wr(A_TXB + 0, 8'h96); wr(A_TXLEN, 1); wr(A_RXLEN, 1); wr(A_READY, 1);
    m_out[0] = 8'hE7;
    spi_xfer(0, 1, 1'b1, 8'h96);
    check("R7 tx byte after early edges", m_got[0], 8'h96);
    rd_check("R7 rx byte after early edges", A_RXB + 0, 8'hE7);
    rd_check("R7 rx count", A_RXCNT, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    we = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_mode0_owned();
    test_other_modes();
    test_not_ready();
    test_early_edges();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule